// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Engine with CRC-8

This block carries out the memory-level command flows of a single-wire slave once the slave has been selected on the bus. A bus layer turns wire activity into three events: a bus reset, a received byte, and a request for the next byte to send. The engine decodes a command byte and picks up a 16-bit address. It then streams data bytes out of, or into, a small behavioural one-time-programmable store while the address advances. At fixed points in each flow it inserts a CRC-8 response byte.

Two regions are served. The general region holds four 32-byte pages that start erased to zeros and only gain ones. The status region holds eight bytes that start erased to ones and only lose them. Status byte 0 holds the page locks. In place of the high-voltage programming pulse there is a program-strobe input. A write is committed only when that strobe arrives after the CRC response has been sent.

Top module: `otp_cmd_engine`

## Requirements
- R1: Every CRC byte is a CRC-8 with polynomial x^8+x^5+x^4+1, fed least significant bit first. For each bit, when crc[0] xor the bit is 1 the value becomes (crc >> 1) xor 0x8C, and otherwise it is crc >> 1.
- R2: A bus reset restarts the engine in the command-wait state with the CRC at 0, whatever state it was in. A bus reset takes priority over every other input in the same cycle.
- R3: A command byte other than 0xF0, 0x0F, 0xAA or 0x55 sends the engine to idle. In idle, received bytes and strobes have no effect until the next bus reset.
- R4: 0xF0 reads the general region (0x0000 to 0x007F) and 0xAA reads the status region (0x0000 to 0x0007). The address arrives low byte first. The first response is the CRC of the command and both address bytes. After it come the data bytes, starting at that address and incrementing.
- R5: After the byte at the last address of the region has been sent on a read, the next response is the CRC of all data bytes sent since the first CRC. The engine then goes idle.
- R6: 0x0F writes the general region and 0x55 writes the status region. After the first data byte, the response is the CRC of the command, both address bytes and the data. For each later byte, the CRC starts from the low 8 bits of the current address and then takes in the data byte.
- R7: General bytes read 0x00 when erased. A committed write ORs the data into the stored byte.
- R8: Status bytes read 0xFF when erased. A committed write ANDs the data into the stored byte.
- R9: Bit p of status byte 0, when 0, locks general page p (address bits 6:5). A write to a locked page still returns its CRC and read-back byte but leaves the store unchanged.
- R10: A write is committed only by a program strobe that arrives after its CRC response has been sent. A strobe at any other time is ignored. A bus reset before the strobe, or in the same cycle, discards the pending write.
- R11: After a committed strobe, the next response is the stored byte at the write address. The address then advances, or after the region's last address the engine goes idle.
- R12: An address outside the selected region sends the engine to idle instead of producing a response.
- R13: Each send request is answered on the following cycle with tx_valid high. The byte is 0xFF whenever the current state has nothing to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also erases the behavioural store |
| bus_reset | input | 1 | One-cycle pulse: a reset was seen on the wire |
| rx_valid | input | 1 | One-cycle pulse: rx_byte holds a byte sent by the host |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle pulse: the bus layer needs the next byte to send |
| prog_strobe | input | 1 | Programming pulse stand-in that commits a pending write |
| tx_valid | output | 1 | Answer to tx_req, one cycle later |
| tx_byte | output | 8 | Byte to send, valid with tx_valid |

## Verification
The critical collision is a bus reset that arrives in the same cycle as the program strobe while a write is waiting for it. The bench raises both pulses on the same clock edge after collecting the CRC response. It then reads the addressed byte back with a fresh read command and expects the value from before the write. A second case sends the strobe early, before the CRC has been requested, to show that the strobe is not accepted out of order. A third case lets a send request land while the engine is still collecting address bytes; the bench expects 0xFF and an unchanged address flow.

// File: rtl/otpe_pkg.sv
package otpe_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ALO,
        S_AHI,
        S_RD_CRC,
        S_RD_DATA,
        S_RD_END,
        S_WR_DATA,
        S_WR_CRC,
        S_WR_PROG,
        S_WR_VFY
    } state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_GEN,
        K_STAT
    } region_e;

    localparam logic [7:0] OP_GEN_READ   = 8'hF0;
    localparam logic [7:0] OP_GEN_WRITE  = 8'h0F;
    localparam logic [7:0] OP_STAT_READ  = 8'hAA;
    localparam logic [7:0] OP_STAT_WRITE = 8'h55;

    localparam logic [7:0] CRC_POLY_LSB  = 8'h8C;
    localparam logic [7:0] GEN_ERASED    = 8'h00;
    localparam logic [7:0] STAT_ERASED   = 8'hFF;
    localparam logic [7:0] IDLE_LINE     = 8'hFF;

    typedef struct packed {
        state_e      st;
        region_e     rgn;
        logic        first;
        logic [15:0] addr;
        logic [7:0]  crc;
        logic [7:0]  wdata;
        logic        tx_v;
        logic [7:0]  tx_b;
    } eng_t;

endpackage

// File: rtl/otpe_crc8.sv
module otpe_crc8 #(
    parameter logic [7:0] POLY = otpe_pkg::CRC_POLY_LSB
) (
    input  logic [7:0] seed,
    input  logic [7:0] data,
    output logic [7:0] result
);
    logic [7:0] stage [9];

    assign stage[0] = seed;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        always_comb begin
            if (stage[b][0] ^ data[b]) begin
                stage[b+1] = (stage[b] >> 1) ^ POLY;
            end else begin
                stage[b+1] = stage[b] >> 1;
            end
        end
    end

    assign result = stage[8];
endmodule

// File: rtl/otpe_cmd_decode.sv
module otpe_cmd_decode
    import otpe_pkg::*;
(
    input  logic [7:0] opcode,
    output logic       known,
    output logic       is_write,
    output region_e    region
);
    always_comb begin
        known    = 1'b1;
        is_write = 1'b0;
        region   = K_NONE;
        unique case (opcode)
            OP_GEN_READ: begin
                region = K_GEN;
            end
            OP_GEN_WRITE: begin
                region   = K_GEN;
                is_write = 1'b1;
            end
            OP_STAT_READ: begin
                region = K_STAT;
            end
            OP_STAT_WRITE: begin
                region   = K_STAT;
                is_write = 1'b1;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/otpe_store.sv
module otpe_store
    import otpe_pkg::*;
#(
    parameter int GEN_PAGES  = 4,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8,
    localparam int GEN_BYTES = GEN_PAGES * PAGE_BYTES,
    localparam int GA_W      = $clog2(GEN_BYTES),
    localparam int SA_W      = $clog2(STAT_BYTES),
    localparam int PG_LSB    = $clog2(PAGE_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_stat,
    input  logic [GA_W-1:0] gen_idx,
    input  logic [SA_W-1:0] stat_idx,
    input  logic            we,
    input  logic [7:0]      wdata,
    output logic [7:0]      rd_byte,
    output logic            page_locked
);
    logic [7:0] gen_q  [GEN_BYTES];
    logic [7:0] stat_q [STAT_BYTES];

    logic [GA_W-PG_LSB-1:0] page_idx;
    assign page_idx = gen_idx[GA_W-1:PG_LSB];

    // a lock bit at zero protects its page
    assign page_locked = ~stat_q[0][page_idx];

    for (genvar g = 0; g < GEN_BYTES; g++) begin : g_gen
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gen_q[g] <= GEN_ERASED;
            end else if (we && !sel_stat && gen_idx == GA_W'(g)) begin
                gen_q[g] <= gen_q[g] | wdata;
            end
        end
    end

    for (genvar s = 0; s < STAT_BYTES; s++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[s] <= STAT_ERASED;
            end else if (we && sel_stat && stat_idx == SA_W'(s)) begin
                stat_q[s] <= stat_q[s] & wdata;
            end
        end
    end

    assign rd_byte = sel_stat ? stat_q[stat_idx] : gen_q[gen_idx];
endmodule

// File: rtl/otp_cmd_engine.sv
module otp_cmd_engine
    import otpe_pkg::*;
#(
    parameter int GEN_PAGES  = 4,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    input  logic       prog_strobe,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    localparam int          GEN_BYTES = GEN_PAGES * PAGE_BYTES;
    localparam int          GA_W      = $clog2(GEN_BYTES);
    localparam int          SA_W      = $clog2(STAT_BYTES);
    localparam logic [15:0] GEN_LAST  = 16'(GEN_BYTES - 1);
    localparam logic [15:0] STAT_LAST = 16'(STAT_BYTES - 1);

    eng_t q, d;

    // views used by the bound checker
    state_e      st_w;
    region_e     rgn_w;
    logic [15:0] addr_w;
    logic [7:0]  rd_byte;

    logic        op_known, op_write;
    region_e     op_region;
    logic [7:0]  crc_seed, crc_data, crc_next;
    logic        page_locked, store_we, prog_fire;
    logic [15:0] addr_full, region_last;
    logic        at_last, addr_ok;

    otpe_cmd_decode u_dec (
        .opcode   (rx_byte),
        .known    (op_known),
        .is_write (op_write),
        .region   (op_region)
    );

    // single CRC stage, shared: receive and send never shift in the same cycle
    assign crc_seed = (q.st == S_WR_DATA && !q.first) ? q.addr[7:0] : q.crc;
    assign crc_data = (q.st == S_RD_DATA) ? rd_byte : rx_byte;

    otpe_crc8 u_crc (
        .seed   (crc_seed),
        .data   (crc_data),
        .result (crc_next)
    );

    otpe_store #(
        .GEN_PAGES  (GEN_PAGES),
        .PAGE_BYTES (PAGE_BYTES),
        .STAT_BYTES (STAT_BYTES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_stat    (q.rgn == K_STAT),
        .gen_idx     (q.addr[GA_W-1:0]),
        .stat_idx    (q.addr[SA_W-1:0]),
        .we          (store_we),
        .wdata       (q.wdata),
        .rd_byte     (rd_byte),
        .page_locked (page_locked)
    );

    assign region_last = (q.rgn == K_STAT) ? STAT_LAST : GEN_LAST;
    assign at_last     = (q.addr == region_last);
    assign addr_full   = {rx_byte, q.addr[7:0]};
    assign addr_ok     = (q.rgn != K_NONE) && (addr_full <= region_last);

    assign prog_fire = (q.st == S_WR_PROG) && prog_strobe && !bus_reset;
    assign store_we  = prog_fire && ((q.rgn == K_STAT) || !page_locked);

    always_comb begin
        d      = q;
        d.tx_v = tx_req;
        d.tx_b = IDLE_LINE;

        if (bus_reset) begin
            d.st    = S_CMD;
            d.rgn   = K_NONE;
            d.first = 1'b1;
            d.addr  = '0;
            d.crc   = '0;
            d.wdata = '0;
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    d.st = S_IDLE;
                end
                S_CMD: begin
                    if (rx_valid) begin
                        if (op_known) begin
                            d.rgn   = op_region;
                            d.first = op_write;
                            d.crc   = crc_next;
                            d.st    = S_ALO;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                S_ALO: begin
                    if (rx_valid) begin
                        d.addr[7:0] = rx_byte;
                        d.crc       = crc_next;
                        d.st        = S_AHI;
                    end
                end
                S_AHI: begin
                    if (rx_valid) begin
                        d.addr[15:8] = rx_byte;
                        d.crc        = crc_next;
                        if (!addr_ok) begin
                            d.st = S_IDLE;
                        end else if (q.first) begin
                            d.st = S_WR_DATA;
                        end else begin
                            d.st = S_RD_CRC;
                        end
                    end
                end
                S_RD_CRC: begin
                    if (tx_req) begin
                        d.tx_b = q.crc;
                        d.crc  = '0;
                        d.st   = S_RD_DATA;
                    end
                end
                S_RD_DATA: begin
                    if (tx_req) begin
                        d.tx_b = rd_byte;
                        d.crc  = crc_next;
                        if (at_last) begin
                            d.st = S_RD_END;
                        end else begin
                            d.addr = q.addr + 16'd1;
                        end
                    end
                end
                S_RD_END: begin
                    if (tx_req) begin
                        d.tx_b = q.crc;
                        d.crc  = '0;
                        d.st   = S_IDLE;
                    end
                end
                S_WR_DATA: begin
                    if (rx_valid) begin
                        d.wdata = rx_byte;
                        d.crc   = crc_next;
                        d.st    = S_WR_CRC;
                    end
                end
                S_WR_CRC: begin
                    if (tx_req) begin
                        d.tx_b = q.crc;
                        d.crc  = '0;
                        d.st   = S_WR_PROG;
                    end
                end
                S_WR_PROG: begin
                    if (prog_fire) begin
                        d.st = S_WR_VFY;
                    end
                end
                S_WR_VFY: begin
                    if (tx_req) begin
                        d.tx_b  = rd_byte;
                        d.first = 1'b0;
                        if (at_last) begin
                            d.st = S_IDLE;
                        end else begin
                            d.addr = q.addr + 16'd1;
                            d.st   = S_WR_DATA;
                        end
                    end
                end
                default: begin
                    d.st = S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.rgn   <= K_NONE;
            q.first <= 1'b0;
            q.addr  <= '0;
            q.crc   <= '0;
            q.wdata <= '0;
            q.tx_v  <= 1'b0;
            q.tx_b  <= IDLE_LINE;
        end else begin
            q <= d;
        end
    end

    assign tx_valid = q.tx_v;
    assign tx_byte  = q.tx_b;
    assign st_w     = q.st;
    assign rgn_w    = q.rgn;
    assign addr_w   = q.addr;
endmodule

// File: rtl/otp_cmd_engine_chk.sv
module otp_cmd_engine_chk
    import otpe_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_reset,
    input logic        tx_req,
    input logic        tx_valid,
    input logic        prog_strobe,
    input state_e      st_w,
    input region_e     rgn_w,
    input logic [15:0] addr_w,
    input logic [7:0]  rd_byte
);
    // R13: every send request gets an answer on the next cycle
    a_r13_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);

    // R13: no answer without a request
    a_r13_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);

    // R2: bus reset always lands in command-wait
    a_r2_reset_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> st_w == S_CMD);

    // R3: idle is left only through a bus reset
    a_r3_idle_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w == S_IDLE && !bus_reset) |=> st_w == S_IDLE);

    // R10: a pending write waits for its strobe
    a_r10_wait_for_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w == S_WR_PROG && !prog_strobe && !bus_reset) |=> st_w == S_WR_PROG);

    // R7: a general byte never loses a one
    a_r7_gen_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_w == K_GEN && $past(rgn_w) == K_GEN && $stable(addr_w))
        |-> (($past(rd_byte) & ~rd_byte) == 8'h00));

    // R8: a status byte never gains a one
    a_r8_stat_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn_w == K_STAT && $past(rgn_w) == K_STAT && $stable(addr_w))
        |-> ((~$past(rd_byte) & rd_byte) == 8'h00));
endmodule

bind otp_cmd_engine otp_cmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset   (bus_reset),
    .tx_req      (tx_req),
    .tx_valid    (tx_valid),
    .prog_strobe (prog_strobe),
    .st_w        (st_w),
    .rgn_w       (rgn_w),
    .addr_w      (addr_w),
    .rd_byte     (rd_byte)
);

// File: tb/otp_cmd_engine_test.sv
module otp_cmd_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       prog_strobe = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int tests = 0;
    int fails = 0;

    logic [7:0] gen_m  [128];
    logic [7:0] stat_m [8];

    always #5 clk = ~clk;

    otp_cmd_engine uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_req      (tx_req),
        .prog_strobe (prog_strobe),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte)
    );

    function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 8'h8C;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic fetch(output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        if (tx_valid !== 1'b1) begin
            tests++; fails++;
            $display("FAIL R13: got tx_valid %0b expected 1", tx_valid);
        end
        b = tx_byte;
    endtask

    task automatic strobe();
        @(negedge clk); prog_strobe = 1'b1;
        @(negedge clk); prog_strobe = 1'b0;
    endtask

    function automatic logic [7:0] last_of(input bit stat);
        return stat ? 8'h07 : 8'h7F;
    endfunction

    function automatic logic [7:0] model_rd(input bit stat, input logic [7:0] a);
        return stat ? stat_m[a[2:0]] : gen_m[a[6:0]];
    endfunction

    task automatic model_wr(input bit stat, input logic [7:0] a, input logic [7:0] v);
        if (stat) stat_m[a[2:0]] = stat_m[a[2:0]] & v;
        else if (stat_m[0][a[6:5]]) gen_m[a[6:0]] = gen_m[a[6:0]] | v;
    endtask

    // read from address a up to the region end
    task automatic rd_run(input bit stat, input logic [7:0] a, input string tag);
        logic [7:0] c = 8'h00;
        logic [7:0] b;
        logic [7:0] op = stat ? 8'hAA : 8'hF0;
        pulse_reset();
        send(op);   c = crc_step(c, op);
        send(a);    c = crc_step(c, a);
        send(8'h00); c = crc_step(c, 8'h00);
        fetch(b); check({tag, " R4 addr crc"}, b, c);
        c = 8'h00;
        for (int k = int'(a); k <= int'(last_of(stat)); k++) begin
            fetch(b);
            check({tag, " data"}, b, model_rd(stat, 8'(k)));
            c = crc_step(c, model_rd(stat, 8'(k)));
        end
        fetch(b); check("R5 end crc", b, c);
        fetch(b); check("R5 idle after end", b, 8'hFF);
    endtask

    // write n bytes starting at a, with random data
    task automatic wr_run(input bit stat, input logic [7:0] a, input int n, input string tag);
        logic [7:0] c = 8'h00;
        logic [7:0] b, v;
        logic [7:0] cur = a;
        logic [7:0] op = stat ? 8'h55 : 8'h0F;
        pulse_reset();
        send(op);    c = crc_step(c, op);
        send(a);     c = crc_step(c, a);
        send(8'h00); c = crc_step(c, 8'h00);
        for (int k = 0; k < n; k++) begin
            v = 8'($urandom);
            send(v);
            c = (k == 0) ? crc_step(c, v) : crc_step(cur, v);
            fetch(b); check("R6 write crc", b, c);
            strobe();
            model_wr(stat, cur, v);
            fetch(b); check({tag, " R11 readback"}, b, model_rd(stat, cur));
            if (cur == last_of(stat)) begin
                fetch(b); check("R11 idle after last", b, 8'hFF);
                break;
            end
            cur = cur + 8'd1;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] b, c, v, a;
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) gen_m[i] = 8'h00;
        for (int i = 0; i < 8; i++) stat_m[i] = 8'hFF;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state: idle answers with released line
        fetch(b); check("R13 reset idle line", b, 8'hFF);
        send(8'hF0);
        fetch(b); check("R3 idle ignores bytes", b, 8'hFF);

        // R1 known vector: CRC of F0 00 00 computed by the reference loop
        pulse_reset();
        send(8'hF0); send(8'h00); send(8'h00);
        fetch(b);
        c = crc_step(crc_step(crc_step(8'h00, 8'hF0), 8'h00), 8'h00);
        check("R1 crc of command and address", b, c);

        // R7 erased general reads, R8 erased status reads, R5 ending
        rd_run(1'b0, 8'h7C, "R7 erased");
        rd_run(1'b1, 8'h00, "R8 erased");

        // R7 OR semantics: two writes over one byte, run across two bytes
        wr_run(1'b0, 8'h10, 3, "R7");
        wr_run(1'b0, 8'h10, 2, "R7 or");
        // R11 idle after last general address
        wr_run(1'b0, 8'h7E, 3, "R11");
        // R8 AND semantics on status bytes (byte 0 left alone)
        wr_run(1'b1, 8'h03, 2, "R8");
        wr_run(1'b1, 8'h03, 1, "R8 and");

        // random mix
        for (int it = 0; it < 30; it++) begin
            a = 8'($urandom_range(0, 127));
            if (it % 6 == 5) rd_run(1'b0, 8'h70 | (a & 8'h0F), "R4 random");
            else wr_run(1'b0, a, int'($urandom_range(1, 3)), "R7 random");
        end

        // R3 unknown command
        pulse_reset();
        send(8'h3C);
        send(8'h00);
        fetch(b); check("R3 unknown cmd idle", b, 8'hFF);

        // R12 out of range addresses
        pulse_reset();
        send(8'hF0); send(8'h80); send(8'h00);
        fetch(b); check("R12 general past end", b, 8'hFF);
        pulse_reset();
        send(8'hAA); send(8'h02); send(8'h01);
        fetch(b); check("R12 high byte set", b, 8'hFF);
        pulse_reset();
        send(8'h55); send(8'h08); send(8'h00);
        fetch(b); check("R12 status past end", b, 8'hFF);

        // R13 send request during address collection does not disturb
        pulse_reset();
        c = 8'h00;
        send(8'hF0); c = crc_step(c, 8'hF0);
        fetch(b); check("R13 nothing to send", b, 8'hFF);
        send(8'h7F); c = crc_step(c, 8'h7F);
        send(8'h00); c = crc_step(c, 8'h00);
        fetch(b); check("R4 crc after interleaved request", b, c);
        fetch(b); check("R4 data at 7F", b, gen_m[127]);

        // R10 strobe before CRC request is ignored, then reset discards
        v = ~gen_m[8'h40];
        pulse_reset();
        send(8'h0F); send(8'h40); send(8'h00); send(v);
        strobe();
        fetch(b);
        c = crc_step(crc_step(crc_step(crc_step(8'h00, 8'h0F), 8'h40), 8'h00), v);
        check("R10 crc still pending", b, c);
        pulse_reset();
        rd_run(1'b0, 8'h78, "R10 unrelated");
        pulse_reset();
        send(8'hF0); send(8'h40); send(8'h00);
        fetch(b);
        fetch(b); check("R10 early strobe discarded", b, gen_m[8'h40]);

        // R10 reset and strobe in the same cycle
        v = ~gen_m[8'h41];
        pulse_reset();
        send(8'h0F); send(8'h41); send(8'h00); send(v);
        fetch(b);
        @(negedge clk); bus_reset = 1'b1; prog_strobe = 1'b1;
        @(negedge clk); bus_reset = 1'b0; prog_strobe = 1'b0;
        send(8'hF0); send(8'h41); send(8'h00);
        fetch(b);
        fetch(b); check("R10 reset wins over strobe", b, gen_m[8'h41]);

        // R9 lock page 1 (status byte 0 bit 1 cleared)
        pulse_reset();
        send(8'h55); send(8'h00); send(8'h00); send(8'hFD);
        fetch(b); strobe(); model_wr(1'b1, 8'h00, 8'hFD);
        fetch(b); check("R9 lock byte readback", b, 8'hFD);
        v = ~gen_m[8'h25];
        pulse_reset();
        send(8'h0F); send(8'h25); send(8'h00); send(v);
        c = crc_step(crc_step(crc_step(crc_step(8'h00, 8'h0F), 8'h25), 8'h00), v);
        fetch(b); check("R9 locked write still gives crc", b, c);
        strobe();
        fetch(b); check("R9 locked page unchanged", b, gen_m[8'h25]);
        wr_run(1'b0, 8'h05, 1, "R9 page0 open");
        wr_run(1'b0, 8'h3F, 1, "R9 page1 end");

        // final sweep of both regions
        rd_run(1'b0, 8'h00, "R7 sweep");
        rd_run(1'b1, 8'h00, "R8 sweep");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule